// File: doc/BRIEF.md
# Processor Presence Bitmap Port

This block presents a read-only bitmap on a small byte-wide I/O window, with one bit for each processor slot. A slot's bit sits at the position given by the processor's interrupt-controller ID, so byte n, bit k describes processor 8n+k. The boot processor's bit is always set. A hot-add pulse, carrying the ID of the new processor, sets that slot's bit and raises bit 2 of a general-purpose event status byte. When that status bit and the matching enable input are both high, the system control interrupt output is asserted. Firmware services the interrupt by reading the bitmap, and then clears the status bit with a write-one-to-clear strobe.

Host writes never change the bitmap. A byte write of 0x00 to any of the four bytes of the first 32-bit word is treated instead as a request to change modes. It sets a sticky output that hands the window over to the newer hotplug register interface. From that point the bitmap stops answering, and all of its reads return 0. Only a reset returns the port to legacy mode. Hot-removal is not supported, so a set bit is never cleared except by reset.

Top module: `cpu_presence_port`

## Requirements
- R1: A read of byte offset n returns, in bit k, the presence bit of the processor whose ID is 8n+k. The read data is combinational on `io_addr_i` while `io_rd_i` is high.
- R2: A host write to any offset with any nonzero value leaves every bitmap bit unchanged, and so does a zero write to offsets 4 to 31.
- R3: After reset, only bit 0 (the boot processor) is set. Bit 0 reads as 1 in every legacy-mode read of offset 0.
- R4: A hot-add pulse whose ID is below MAX_CPUS sets that ID's bit and `gpe_sts_o` bit 2, both visible from the next cycle. This happens even when the bit was already set.
- R5: `sci_o` is 1 exactly when `gpe_sts_o` bit 2 and `gpe_en_i` are both 1.
- R6: A `gpe_clr_i` pulse clears `gpe_sts_o` bit 2 on the next cycle, unless a valid hot-add arrives in the same cycle, in which case the bit stays set. All other bits of `gpe_sts_o` read 0.
- R7: A byte write of 0x00 to offset 0, 1, 2 or 3 sets `modern_o` from the next cycle.
- R8: `modern_o` stays 1 until reset. While it is 1, all bitmap reads return 0.
- R9: Bits for IDs at or above MAX_CPUS read 0, including whole bytes past the last slot. A hot-add with such an ID changes neither the bitmap nor `gpe_sts_o`.
- R10: `io_rdata_o` is 0 whenever `io_rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_addr_i | input | ADDR_W (5) | Byte offset within the window |
| io_wr_i | input | 1 | Byte write strobe |
| io_rd_i | input | 1 | Byte read strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data |
| hot_add_i | input | 1 | Hot-add pulse, one cycle |
| hot_add_id_i | input | ID_W (4) | Interrupt-controller ID of the added processor |
| gpe_en_i | input | 1 | Enable for event status bit 2 |
| gpe_clr_i | input | 1 | Write of 1 to event status bit 2 (clears it) |
| gpe_sts_o | output | 8 | Event status byte; only bit 2 is live |
| sci_o | output | 1 | System control interrupt |
| modern_o | output | 1 | Sticky hand-over to the newer register interface |

## Verification
The bench adds every ID from 0 to 15 to a 12-slot configuration, and after each add it sweeps all 32 offsets. A swapped bit index, or a missing range check, would show up as set bits in the wrong place or in the dead tail of byte 1. Zero writes to offsets 4 to 31 and nonzero writes everywhere must neither change the map nor switch modes. A decoder that compares the wrong address range, or tests for any write rather than a zero write, would flip `modern_o` at the wrong time. Each of offsets 0 to 3 is tried as the switch offset after a fresh reset, with a check that the switch sticks and that reads then return 0. A clear that collides with a hot-add must leave the status bit set, or the new event would be lost.

// File: rtl/cpp_pkg.sv
package cpp_pkg;
  typedef logic [7:0] io_byte_t;
  localparam int unsigned GPE_HOTADD_BIT = 2;
  localparam int unsigned SWITCH_BYTES   = 4;
endpackage

// File: rtl/cpp_bitmap.sv
module cpp_bitmap #(
  parameter int unsigned MAX_CPUS  = 12,
  parameter int unsigned WIN_BYTES = 32,
  localparam int unsigned ADDR_W   = $clog2(WIN_BYTES),
  localparam int unsigned ID_W     = (MAX_CPUS > 1) ? $clog2(MAX_CPUS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hot_add_i,
  input  logic [ID_W-1:0]   hot_add_id_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output cpp_pkg::io_byte_t rd_byte_o,
  output logic              add_ok_o
);
  localparam logic [ID_W:0] ID_LIM = (ID_W+1)'(MAX_CPUS);

  logic [MAX_CPUS-1:0]    map_q;
  logic [WIN_BYTES*8-1:0] pad;

  assign add_ok_o = hot_add_i && ({1'b0, hot_add_id_i} < ID_LIM);

  // bit 0 resets to 1 and no path clears a bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) map_q <= MAX_CPUS'(1);
    else if (add_ok_o) map_q[hot_add_id_i] <= 1'b1;
  end

  for (genvar i = 0; i < WIN_BYTES*8; i++) begin : g_pad
    if (i < MAX_CPUS) begin : g_live
      assign pad[i] = map_q[i];
    end else begin : g_dead
      assign pad[i] = 1'b0;
    end
  end

  assign rd_byte_o = pad[rd_addr_i*8 +: 8];

  assert_map_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hot_add_i |=> $stable(map_q));
  assert_no_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(map_q) & ~map_q) == '0));
  assert_boot_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_q[0]);
endmodule

// File: rtl/cpp_gpe.sv
module cpp_gpe (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              add_ok_i,
  input  logic              gpe_en_i,
  input  logic              gpe_clr_i,
  output cpp_pkg::io_byte_t gpe_sts_o,
  output logic              sci_o
);
  logic sts_q;

  // set has priority so a colliding event is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sts_q <= 1'b0;
    else if (add_ok_i)  sts_q <= 1'b1;
    else if (gpe_clr_i) sts_q <= 1'b0;
  end

  always_comb begin
    gpe_sts_o = '0;
    gpe_sts_o[cpp_pkg::GPE_HOTADD_BIT] = sts_q;
  end
  assign sci_o = sts_q & gpe_en_i;

  assert_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_ok_i |=> gpe_sts_o[cpp_pkg::GPE_HOTADD_BIT]);
  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpe_clr_i && !add_ok_i) |=> !gpe_sts_o[cpp_pkg::GPE_HOTADD_BIT]);
endmodule

// File: rtl/cpp_mode.sv
module cpp_mode #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_wr_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  cpp_pkg::io_byte_t io_wdata_i,
  output logic              modern_o
);
  logic modern_q, hit;

  assign hit = io_wr_i && (io_wdata_i == 8'h00) &&
               (32'(io_addr_i) < cpp_pkg::SWITCH_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) modern_q <= 1'b0;
    else if (hit) modern_q <= 1'b1;
  end
  assign modern_o = modern_q;

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    modern_q |=> modern_q);
  assert_switch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> modern_q);
endmodule

// File: rtl/cpu_presence_port.sv
module cpu_presence_port #(
  parameter int unsigned MAX_CPUS  = 12,
  parameter int unsigned WIN_BYTES = 32,
  localparam int unsigned ADDR_W   = $clog2(WIN_BYTES),
  localparam int unsigned ID_W     = (MAX_CPUS > 1) ? $clog2(MAX_CPUS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  input  logic              hot_add_i,
  input  logic [ID_W-1:0]   hot_add_id_i,
  input  logic              gpe_en_i,
  input  logic              gpe_clr_i,
  output logic [7:0]        gpe_sts_o,
  output logic              sci_o,
  output logic              modern_o
);
  localparam int unsigned LIVE_BYTES = (MAX_CPUS + 7) / 8;

  cpp_pkg::io_byte_t map_byte;
  logic              add_ok;

  cpp_bitmap #(.MAX_CPUS(MAX_CPUS), .WIN_BYTES(WIN_BYTES)) u_map (
    .clk_i, .rst_ni, .hot_add_i, .hot_add_id_i,
    .rd_addr_i(io_addr_i), .rd_byte_o(map_byte), .add_ok_o(add_ok)
  );

  cpp_gpe u_gpe (
    .clk_i, .rst_ni, .add_ok_i(add_ok), .gpe_en_i, .gpe_clr_i,
    .gpe_sts_o, .sci_o
  );

  cpp_mode #(.ADDR_W(ADDR_W)) u_mode (
    .clk_i, .rst_ni, .io_wr_i, .io_addr_i, .io_wdata_i, .modern_o
  );

  assign io_rdata_o = (io_rd_i && !modern_o) ? map_byte : 8'h00;

  assert_boot_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && !modern_o && io_addr_i == '0) |-> io_rdata_o[0]);
  assert_tail_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && 32'(io_addr_i) >= LIVE_BYTES) |-> io_rdata_o == 8'h00);
  assert_modern_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    modern_o |-> io_rdata_o == 8'h00);
  assert_idle_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rd_i |-> io_rdata_o == 8'h00);
endmodule

// File: tb/sim_cpu_presence_port.sv
`timescale 1ns/1ps
module sim_cpu_presence_port;
  localparam int NC = 12;
  logic clk = 0, rst_ni = 0;
  logic [4:0] io_addr = 0;
  logic io_wr = 0, io_rd = 0;
  logic [7:0] io_wdata = 0, io_rdata, gpe_sts;
  logic hot_add = 0, gpe_en = 0, gpe_clr = 0, sci, modern;
  logic [3:0] hot_id = 0;
  int checks = 0, fails = 0;
  logic [15:0] exp_map;

  always #5 clk = ~clk;

  cpu_presence_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .io_addr_i(io_addr), .io_wr_i(io_wr),
    .io_rd_i(io_rd), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .hot_add_i(hot_add), .hot_add_id_i(hot_id), .gpe_en_i(gpe_en),
    .gpe_clr_i(gpe_clr), .gpe_sts_o(gpe_sts), .sci_o(sci), .modern_o(modern)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int a);
    logic [7:0] b = 0;
    for (int k = 0; k < 8; k++) if (a*8+k < NC) b[k] = exp_map[a*8+k];
    return b;
  endfunction

  task automatic rd_all(input string req, input logic quiet);
    for (int a = 0; a < 32; a++) begin
      @(negedge clk); io_addr = 5'(a); io_rd = 1; #1;
      chk(req, io_rdata, quiet ? 8'h00 : exp_byte(a));
      io_rd = 0; #1;
      chk("R10", io_rdata, 8'h00);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); io_addr = 5'(a); io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_ni = 0; @(negedge clk); rst_ni = 1;
    exp_map = 16'h0001;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    exp_map = 16'h0001;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    // reset state
    chk("R3", gpe_sts, 8'h00);
    chk("R8", modern, 0);
    rd_all("R3", 0);

    // hot-add sweep over all ids, enable toggling
    for (int id = 0; id < 16; id++) begin
      @(negedge clk); hot_add = 1; hot_id = 4'(id); gpe_en = id[0];
      @(negedge clk); hot_add = 0;
      if (id < NC) begin
        exp_map[id] = 1;
        chk("R4", gpe_sts, 8'h04);
        chk("R5", sci, id[0]);
      end else begin
        chk("R9", gpe_sts, 8'h00);
        chk("R5", sci, 0);
      end
      rd_all(id < NC ? "R1" : "R9", 0);
      gpe_clr = 1; @(negedge clk); gpe_clr = 0;
      chk("R6", gpe_sts, 8'h00);
      chk("R5", sci, 0);
    end

    // re-add of a present cpu still raises the event
    @(negedge clk); hot_add = 1; hot_id = 4'd3; gpe_en = 1;
    @(negedge clk); hot_add = 0;
    chk("R4", gpe_sts, 8'h04);
    chk("R5", sci, 1);
    gpe_en = 0; #1; chk("R5", sci, 0);
    // clear collides with valid add: stays set
    @(negedge clk); hot_add = 1; hot_id = 4'd5; gpe_clr = 1;
    @(negedge clk); hot_add = 0; gpe_clr = 0;
    chk("R6", gpe_sts, 8'h04);
    // clear colliding with out-of-range add: clears
    @(negedge clk); hot_add = 1; hot_id = 4'd13; gpe_clr = 1;
    @(negedge clk); hot_add = 0; gpe_clr = 0;
    chk("R6", gpe_sts, 8'h00);

    // writes do not change map; zero above word 0 does not switch
    do_reset;
    @(negedge clk); hot_add = 1; hot_id = 4'd9;
    @(negedge clk); hot_add = 0; exp_map[9] = 1;
    for (int a = 0; a < 32; a++) begin
      wr(a, 8'hFF); wr(a, 8'h5A);
      if (a >= 4) wr(a, 8'h00);
      chk("R7", modern, 0);
    end
    rd_all("R2", 0);

    // each switch offset after a fresh reset
    for (int s = 0; s < 4; s++) begin
      do_reset;
      chk("R8", modern, 0);
      wr(s, 8'h00);
      chk("R7", modern, 1);
      wr(s, 8'h11); wr(0, 8'h00);
      @(negedge clk); hot_add = 1; hot_id = 4'd2;
      @(negedge clk); hot_add = 0;
      chk("R8", modern, 1);
      rd_all("R8", 1);
    end
    do_reset;
    chk("R8", modern, 0);
    rd_all("R3", 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule